// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit owns the two special result registers (HI and LO) of a 32-bit integer core. It executes the multiply, divide and HI/LO move operations of the SPECIAL opcode group. The core presents a function code, the two source operand values, a destination register index and a one-cycle start strobe. Multiplies and moves finish in one cycle. Divides run a restoring shift-subtract loop of 32 iterations, and `busy` stays high for that whole time.

A 64-bit product is split so that its upper word goes to HI and its lower word to LO. A division leaves the quotient in LO and the remainder in HI. Signed division truncates toward zero, and its remainder takes the sign of the dividend. The move-from forms return HI or LO on a general-register writeback port one cycle after they are accepted. Hazard detection belongs to the pipeline around the unit. The unit's part is to hold `busy` until its divide result is final, and to ignore any start that arrives while `busy` is high.

Top module: `mdu_hilo`

## Requirements
- R1: With `funct` = 0x18, HI:LO receives the 64-bit signed product of `rs_val` and `rt_val`, upper word in HI. `done` pulses in the cycle after the start, and `busy` stays low.
- R2: With `funct` = 0x19, HI:LO receives the 64-bit unsigned product, split the same way. `done` pulses in the cycle after the start.
- R3: With `funct` = 0x1A and a non-zero divisor, LO receives the signed quotient truncated toward zero, and HI receives the remainder with the dividend's sign. The case 0x80000000 / -1 gives LO = 0x80000000 and HI = 0.
- R4: With `funct` = 0x1B and a non-zero divisor, LO receives the unsigned quotient and HI the unsigned remainder.
- R5: With `funct` = 0x11, HI takes `rs_val`. With `funct` = 0x13, LO takes `rs_val`. `done` pulses in the next cycle.
- R6: With `funct` = 0x10 or 0x12, the unit drives `wb_en`=1, `wb_idx`=`rd_idx` and `wb_val` = HI or LO in the cycle after the start, with a `done` pulse. When `rd_idx` is 0, `wb_en` stays 0.
- R7: A divide (0x1A or 0x1B) by zero completes normally. It leaves LO = 0xFFFFFFFF and HI equal to the dividend.
- R8: A divide raises `busy` in the cycle after the start and holds it for exactly 32 cycles. `done` pulses in the cycle `busy` falls, and HI/LO hold the result from that cycle on.
- R9: A start while `busy` is high is ignored: it changes neither HI nor LO and produces no writeback.
- R10: After reset, `busy`, `done` and `wb_en` are 0, and HI and LO read as 0.
- R11: A start with any other function code leaves HI and LO unchanged and produces no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| funct | input | 6 | SPECIAL function code |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| rd_idx | input | 5 | Destination register index for move-from |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | 5 | Register writeback index |
| wb_val | output | 32 | Register writeback data |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Operation completion pulse |

## Verification
Several properties are checked on every cycle. No writeback appears while a divide is running. A writeback never targets register 0. Every fall of `busy` comes with `done` after exactly 32 busy cycles. A zero divisor always yields an all-ones quotient. A multiply finishes with `done` in the next cycle. Reset clears the control outputs. The arithmetic values cannot be shown by these properties. Only the bench scenarios show them, by comparing HI and LO against a behavioural reference over random operands and the sign corner cases, including the most-negative dividend over -1. The bench scenarios also show that moves and starts issued during a divide have no effect.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN = 32;
    localparam int FW   = 6;

    localparam logic [FW-1:0] FN_MFHI  = 6'h10;
    localparam logic [FW-1:0] FN_MTHI  = 6'h11;
    localparam logic [FW-1:0] FN_MFLO  = 6'h12;
    localparam logic [FW-1:0] FN_MTLO  = 6'h13;
    localparam logic [FW-1:0] FN_MULT  = 6'h18;
    localparam logic [FW-1:0] FN_MULTU = 6'h19;
    localparam logic [FW-1:0] FN_DIV   = 6'h1A;
    localparam logic [FW-1:0] FN_DIVU  = 6'h1B;

    typedef enum logic [2:0] {
        K_NONE, K_MUL, K_DIV, K_TO_HI, K_TO_LO, K_FROM_HI, K_FROM_LO
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     sgn;
    } op_t;

    function automatic op_t decode_op(input logic [FW-1:0] f);
        op_t o;
        o.kind = K_NONE;
        o.sgn  = 1'b0;
        case (f)
            FN_MFHI:  o.kind = K_FROM_HI;
            FN_MFLO:  o.kind = K_FROM_LO;
            FN_MTHI:  o.kind = K_TO_HI;
            FN_MTLO:  o.kind = K_TO_LO;
            FN_MULT:  begin o.kind = K_MUL; o.sgn = 1'b1; end
            FN_MULTU: o.kind = K_MUL;
            FN_DIV:   begin o.kind = K_DIV; o.sgn = 1'b1; end
            FN_DIVU:  o.kind = K_DIV;
            default:  o.kind = K_NONE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int W = 32
) (
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ea, eb;

    always_comb begin
        ea   = {{W{sgn & a[W-1]}}, a};
        eb   = {{W{sgn & b[W-1]}}, b};
        prod = ea * eb;
    end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sgn,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] ITER = CW'(W);

    logic [W-1:0]  r_q, q_q, d_q;
    logic [CW-1:0] cnt;
    logic          neg_q, neg_r;

    logic [W:0]    shifted, diff;
    logic          take;
    logic [W-1:0]  r_n, q_n;
    logic [W-1:0]  mag_a, mag_b;

    always_comb begin
        mag_a   = (sgn && dvd[W-1]) ? -dvd : dvd;
        mag_b   = (sgn && dvs[W-1]) ? -dvs : dvs;
        shifted = {r_q, q_q[W-1]};
        diff    = shifted - {1'b0, d_q};
        take    = ~diff[W];
        r_n     = take ? diff[W-1:0] : shifted[W-1:0];
        q_n     = {q_q[W-2:0], take};
        fin     = busy && (cnt == CW'(1));
        quo     = neg_q ? -q_n : q_n;
        rem     = neg_r ? -r_n : r_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '0;
            q_q   <= '0;
            d_q   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
        end else if (busy) begin
            r_q  <= r_n;
            q_q  <= q_n;
            cnt  <= cnt - CW'(1);
            if (cnt == CW'(1))
                busy <= 1'b0;
        end else if (start) begin
            r_q   <= '0;
            q_q   <= mag_a;
            d_q   <= mag_b;
            cnt   <= ITER;
            busy  <= 1'b1;
            neg_q <= sgn && (dvd[W-1] ^ dvs[W-1]) && (dvs != '0);
            neg_r <= sgn && dvd[W-1];
        end
    end

    a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0) && (cnt <= ITER));

    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (fin && d_q == '0) |-> (quo == '1));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] funct,
    input  logic [W-1:0]  rs_val,
    input  logic [W-1:0]  rt_val,
    input  logic [4:0]    rd_idx,
    output logic          wb_en,
    output logic [4:0]    wb_idx,
    output logic [W-1:0]  wb_val,
    output logic          busy,
    output logic          done
);
    localparam int BCW = $clog2(W + 1) + 1;

    logic [W-1:0]   hi_q, lo_q;
    op_t            op;
    logic           go;
    logic [2*W-1:0] prod;
    logic           div_fin;
    logic [W-1:0]   div_quo, div_rem;

    always_comb begin
        op = decode_op(funct);
        go = start && !busy && (op.kind != K_NONE);
    end

    mdu_mul #(.W(W)) u_mul (
        .sgn  (op.sgn),
        .a    (rs_val),
        .b    (rt_val),
        .prod (prod)
    );

    mdu_div #(.W(W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (go && op.kind == K_DIV),
        .sgn   (op.sgn),
        .dvd   (rs_val),
        .dvs   (rt_val),
        .busy  (busy),
        .fin   (div_fin),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done   <= 1'b0;
            wb_en  <= 1'b0;
            wb_idx <= '0;
            wb_val <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            if (div_fin) begin
                hi_q <= div_rem;
                lo_q <= div_quo;
                done <= 1'b1;
            end
            if (go) begin
                case (op.kind)
                    K_MUL: begin
                        hi_q <= prod[2*W-1:W];
                        lo_q <= prod[W-1:0];
                        done <= 1'b1;
                    end
                    K_TO_HI: begin
                        hi_q <= rs_val;
                        done <= 1'b1;
                    end
                    K_TO_LO: begin
                        lo_q <= rs_val;
                        done <= 1'b1;
                    end
                    K_FROM_HI, K_FROM_LO: begin
                        wb_en  <= (rd_idx != '0);
                        wb_idx <= rd_idx;
                        wb_val <= (op.kind == K_FROM_HI) ? hi_q : lo_q;
                        done   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Checker-side counter of consecutive busy cycles
    logic [BCW-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (rst)       busy_len <= '0;
        else if (busy) busy_len <= busy_len + BCW'(1);
        else           busy_len <= '0;
    end

    a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && busy_len == BCW'(W)));

    a_r9_no_wb_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wb_en);

    a_r6_no_zero_wb: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != '0));

    a_r1_mul_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (funct == FN_MULT || funct == FN_MULTU)) |=> (done && !busy));

    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !wb_en));
endmodule

// File: tb/sim_mdu_hilo.sv
module sim_mdu_hilo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  funct = '0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic [4:0]  rd_idx = '0;
    logic        wb_en, busy, done;
    logic [4:0]  wb_idx;
    logic [31:0] wb_val;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdu_hilo u0 (
        .clk(clk), .rst(rst), .start(start), .funct(funct),
        .rs_val(rs_val), .rt_val(rt_val), .rd_idx(rd_idx),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one start at a negedge, return at the negedge after the accepting edge
    task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd);
        @(negedge clk);
        start = 1'b1; funct = f; rs_val = a; rt_val = b; rd_idx = rd;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_reg(input bit hi, input logic [4:0] rd, input string req);
        issue(hi ? 6'h10 : 6'h12, 32'h0, 32'h0, rd);
        chk(done && wb_en && wb_idx == rd, {req, " wb ctl"}, {wb_en, wb_idx}, {1'b1, rd});
        chk(wb_val == (hi ? m_hi : m_lo), {req, hi ? " HI" : " LO"}, wb_val, hi ? m_hi : m_lo);
    endtask

    task automatic do_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string req);
        longint p;
        logic [63:0] pu;
        if (sgn) begin p = longint'($signed(a)) * longint'($signed(b)); pu = p; end
        else pu = {32'h0, a} * {32'h0, b};
        issue(sgn ? 6'h18 : 6'h19, a, b, 5'd3);
        chk(done && !busy, {req, " done"}, {done, busy}, 2'b10);
        m_hi = pu[63:32]; m_lo = pu[31:0];
        read_reg(1, 5'd4, req);
        read_reg(0, 5'd5, req);
    endtask

    task automatic do_div(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string req);
        longint sa, sb;
        logic [31:0] eq, er;
        int bad = 0;
        if (b == 0) begin eq = '1; er = a; end
        else if (sgn) begin
            sa = $signed(a); sb = $signed(b);
            eq = 32'(sa / sb); er = 32'(sa % sb);
        end else begin eq = a / b; er = a % b; end
        issue(sgn ? 6'h1A : 6'h1B, a, b, 5'd3);
        for (int i = 0; i < 32; i++) begin
            if (!busy || done) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 busy window", bad, 0);
        chk(!busy && done, "R8 done at busy fall", {busy, done}, 2'b01);
        m_hi = er; m_lo = eq;
        read_reg(1, 5'd6, req);
        read_reg(0, 5'd7, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !wb_en, "R10 outputs", {busy, done, wb_en}, 3'b000);
        read_reg(1, 5'd1, "R10");
        read_reg(0, 5'd2, "R10");

        // R5 moves to HI/LO
        issue(6'h11, 32'hDEAD_BEEF, 32'h0, 5'd0);
        chk(done, "R5 done", done, 1);
        m_hi = 32'hDEAD_BEEF;
        issue(6'h13, 32'h1234_5678, 32'h0, 5'd0);
        m_lo = 32'h1234_5678;
        read_reg(1, 5'd9, "R5");
        read_reg(0, 5'd10, "R5");

        // R6 rd = 0 suppresses write
        issue(6'h10, 32'h0, 32'h0, 5'd0);
        chk(done && !wb_en, "R6 rd0 suppressed", {done, wb_en}, 2'b10);

        // R11 unknown funct
        issue(6'h20, 32'h5555_5555, 32'h1, 5'd1);
        chk(!done && !wb_en, "R11 no done", {done, wb_en}, 2'b00);
        read_reg(1, 5'd11, "R11");
        read_reg(0, 5'd12, "R11");

        // R1 / R2 corners
        do_mul(1, 32'hFFFF_FFFF, 32'h0000_0002, "R1");
        do_mul(1, 32'h8000_0000, 32'h8000_0000, "R1");
        do_mul(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
        do_mul(0, 32'h8000_0000, 32'h0000_0004, "R2");

        // R3 / R4 corners
        do_div(1, 32'hFFFF_FFF9, 32'h0000_0002, "R3");
        do_div(1, 32'h0000_0007, 32'hFFFF_FFFE, "R3");
        do_div(1, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
        do_div(0, 32'hFFFF_FFFF, 32'h0000_0010, "R4");
        do_div(0, 32'h0000_0003, 32'h0000_0009, "R4");

        // R7 division by zero
        do_div(1, 32'hFFFF_FFF0, 32'h0, "R7");
        do_div(0, 32'h1234_5678, 32'h0, "R7");

        // R9 starts during a divide are ignored
        issue(6'h1B, 32'd100, 32'd7, 5'd3);
        @(negedge clk); start = 1'b1; funct = 6'h11; rs_val = 32'hAAAA_AAAA;
        @(negedge clk); funct = 6'h10; rd_idx = 5'd8;
        @(negedge clk); start = 1'b0;
        chk(!wb_en, "R9 no wb while busy", wb_en, 0);
        while (!done) @(negedge clk);
        m_hi = 32'd2; m_lo = 32'd14;
        read_reg(1, 5'd13, "R9");
        read_reg(0, 5'd14, "R9");

        // random operands against the reference
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b;
            a = $urandom; b = $urandom;
            if (i % 3 == 0) b = b >> (i % 29);
            case (i % 4)
                0: do_mul(1, a, b, "R1 rand");
                1: do_mul(0, a, b, "R2 rand");
                2: do_div(1, a, b, "R3 rand");
                default: do_div(0, a, b, "R4 rand");
            endcase
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule